// File: doc/BRIEF.md
# NAND Controller Event Interrupt Unit

This unit sits beside a NAND flash controller and turns its event signals into one interrupt line. Six sources are watched: a write-protect fault, ECC ready, a decode error, a decode failure, controller ready and NAND ready. The rising edge of each source sets a sticky flag. A mask register picks which flags may drive the active-high, level-sensitive interrupt output.

Software reads the flag register to learn why the interrupt fired, and that read clears every flag. A flag set by an edge in the same cycle as the read survives, so no event is lost. A second read-only view, the live status word, shows the present state of the ready signals and the error flags, plus a 2-bit field for the number of corrected errors. The ECC engine and the NAND timing logic are outside this unit; they only feed it levels and counts.

Top module: `nand_evt_irq`

## Requirements
- R1: After reset all flags read as 0, the mask reads as 0 and `irq` is low.
- R2: A rising edge on `evt_i[k]` sets flag k, visible on `flag_rd_data` one clock later. Bit k means: 0 write-protect fault, 1 ECC ready, 2 decode error, 3 decode failure, 4 controller ready, 5 NAND ready. A source that stays high does not set its flag again after the flag has been cleared.
- R3: When `mask_wr_en` is high at a clock edge, `mask_q` takes `mask_wr_data` from the next cycle on. The mask uses the same bit layout as the flags, and a 1 enables that source.
- R4: `flag_rd_data` always shows the latched flags. When `flag_rd_en` is high at a clock edge, all flags are cleared from the next cycle on.
- R5: A rising edge detected at the same edge as a clearing read leaves that flag set after the read.
- R6: `irq` is high exactly when some bit is set in both the flags and the mask. It stays high until the flag is cleared or the mask bit is removed.
- R7: `live_stat` bit 0 follows `live_nand_rdy`, bit 1 follows `live_ctrl_rdy`, bit 2 follows `live_ecc_rdy`, bit 3 follows `live_err_seen`, bit 6 follows `live_dec_fail`, and bit 7 is 0. The word is combinational, with no clock delay.
- R8: `live_stat[5:4]` holds the corrected-error count `live_corr_cnt` minus one while `live_err_seen` is 1. A count of 0 gives 0, and counts of 4 or more give 3. While `live_err_seen` is 0 the field is 0.
- R9: Flags from different sources accumulate independently until a read clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 6 | Event source levels, in flag bit layout |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | 6 | New mask value |
| mask_q | output | 6 | Current mask |
| flag_rd_en | input | 1 | Flag register read strobe (clears on read) |
| flag_rd_data | output | 6 | Latched flags |
| irq | output | 1 | Level interrupt, active high |
| live_nand_rdy | input | 1 | NAND ready level |
| live_ctrl_rdy | input | 1 | Controller ready level |
| live_ecc_rdy | input | 1 | ECC ready level |
| live_err_seen | input | 1 | Errors detected in last decode |
| live_corr_cnt | input | CNT_W (3) | Number of corrected errors |
| live_dec_fail | input | 1 | Decoder failure level |
| live_stat | output | 8 | Composed live status word |

## Verification
The bench builds the unit with its default parameters: six sources and a 3-bit corrected-error count input. The 3-bit count reaches the saturation point at 4 and beyond, and it also allows the zero count that tests the lower clamp of the minus-one field. With six sources the bench can hit every flag position on its own and combine several. It also lines up an edge with a clearing read in the same cycle to test the no-loss rule.

// File: rtl/irqu_pkg.sv
package irqu_pkg;
    localparam int SRC_N   = 6;
    localparam int LIVE_W  = 8;
    localparam int FIELD_W = 2;

    // flag / mask bit positions
    localparam int F_WP_FAULT  = 0;
    localparam int F_ECC_RDY   = 1;
    localparam int F_DEC_ERR   = 2;
    localparam int F_DEC_FAIL  = 3;
    localparam int F_CTRL_RDY  = 4;
    localparam int F_NAND_RDY  = 5;

    // live status word positions
    localparam int L_NAND_RDY  = 0;
    localparam int L_CTRL_RDY  = 1;
    localparam int L_ECC_RDY   = 2;
    localparam int L_ERR_SEEN  = 3;
    localparam int L_CNT_LO    = 4;
    localparam int L_DEC_FAIL  = 6;

    typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/irqu_edge.sv
module irqu_edge #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= lvl_i[g];
        end
        assign rise_o[g] = lvl_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/irqu_flags.sv
module irqu_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;
    logic [N-1:0] flags_d;

    always_comb begin
        flags_d = clr_i ? '0 : flags_q;
        flags_d = flags_d | rise_i;   // a new edge wins over the clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/irqu_live.sv
module irqu_live
    import irqu_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             nand_rdy,
    input  logic             ctrl_rdy,
    input  logic             ecc_rdy,
    input  logic             err_seen,
    input  logic [CNT_W-1:0] corr_cnt,
    input  logic             dec_fail,
    output logic [LIVE_W-1:0] stat_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(4);

    logic [FIELD_W-1:0] field;

    always_comb begin
        field = '0;
        if (err_seen) begin
            if (corr_cnt == '0)           field = '0;
            else if (corr_cnt >= CNT_SAT) field = '1;
            else                          field = FIELD_W'(corr_cnt - CNT_ONE);
        end
    end

    always_comb begin
        stat_o                          = '0;
        stat_o[L_NAND_RDY]              = nand_rdy;
        stat_o[L_CTRL_RDY]              = ctrl_rdy;
        stat_o[L_ECC_RDY]               = ecc_rdy;
        stat_o[L_ERR_SEEN]              = err_seen;
        stat_o[L_CNT_LO +: FIELD_W]     = field;
        stat_o[L_DEC_FAIL]              = dec_fail;
    end
endmodule

// File: rtl/nand_evt_irq.sv
module nand_evt_irq
    import irqu_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  evt_i,
    input  logic              mask_wr_en,
    input  logic [SRC_N-1:0]  mask_wr_data,
    output logic [SRC_N-1:0]  mask_q,
    input  logic              flag_rd_en,
    output logic [SRC_N-1:0]  flag_rd_data,
    output logic              irq,
    input  logic              live_nand_rdy,
    input  logic              live_ctrl_rdy,
    input  logic              live_ecc_rdy,
    input  logic              live_err_seen,
    input  logic [CNT_W-1:0]  live_corr_cnt,
    input  logic              live_dec_fail,
    output logic [LIVE_W-1:0] live_stat
);
    src_vec_t rise;
    src_vec_t flags;
    src_vec_t mask_r;

    irqu_edge #(.N(SRC_N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (evt_i),
        .rise_o (rise)
    );

    irqu_flags #(.N(SRC_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise),
        .clr_i   (flag_rd_en),
        .flags_o (flags)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)          mask_r <= '0;
        else if (mask_wr_en) mask_r <= mask_wr_data;
    end

    irqu_live #(.CNT_W(CNT_W)) u_live (
        .nand_rdy (live_nand_rdy),
        .ctrl_rdy (live_ctrl_rdy),
        .ecc_rdy  (live_ecc_rdy),
        .err_seen (live_err_seen),
        .corr_cnt (live_corr_cnt),
        .dec_fail (live_dec_fail),
        .stat_o   (live_stat)
    );

    assign mask_q       = mask_r;
    assign flag_rd_data = flags;
    assign irq          = |(flags & mask_r);
endmodule

// File: rtl/nand_evt_irq_chk.sv
module nand_evt_irq_chk
    import irqu_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_N-1:0]  evt_i,
    input logic              mask_wr_en,
    input logic [SRC_N-1:0]  mask_wr_data,
    input logic [SRC_N-1:0]  mask_q,
    input logic              flag_rd_en,
    input logic [SRC_N-1:0]  flag_rd_data,
    input logic              irq,
    input logic              live_nand_rdy,
    input logic              live_ctrl_rdy,
    input logic              live_ecc_rdy,
    input logic              live_err_seen,
    input logic [CNT_W-1:0]  live_corr_cnt,
    input logic              live_dec_fail,
    input logic [LIVE_W-1:0] live_stat
);
    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        // R2 / R5: an edge always leaves its flag set
        a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(evt_i[g]) |=> flag_rd_data[g]);
    end

    // R4: after a read only freshly risen sources may be flagged
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd_en |=> ((flag_rd_data & ~($past(evt_i) & ~$past(evt_i, 2))) == '0));

    // R3
    a_r3_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en |=> (mask_q == $past(mask_wr_data)));

    // R6
    a_r6_irq_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((mask_q != '0) && (flag_rd_data != '0)));

    // R8
    a_r8_field_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !live_err_seen |-> (live_stat[L_CNT_LO +: FIELD_W] == '0));

    // R7
    a_r7_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        live_stat[LIVE_W-1] == 1'b0);
endmodule

bind nand_evt_irq nand_evt_irq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/nand_evt_irq_test.sv
module nand_evt_irq_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_i = '0;
    logic         mask_wr_en = 1'b0;
    logic [N-1:0] mask_wr_data = '0;
    logic [N-1:0] mask_q;
    logic         flag_rd_en = 1'b0;
    logic [N-1:0] flag_rd_data;
    logic         irq;
    logic         live_nand_rdy = 1'b0, live_ctrl_rdy = 1'b0, live_ecc_rdy = 1'b0;
    logic         live_err_seen = 1'b0, live_dec_fail = 1'b0;
    logic [2:0]   live_corr_cnt = '0;
    logic [7:0]   live_stat;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [N-1:0] exp_flags = '0;
    logic [N-1:0] rd_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_evt_irq uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data), .mask_q(mask_q),
        .flag_rd_en(flag_rd_en), .flag_rd_data(flag_rd_data), .irq(irq),
        .live_nand_rdy(live_nand_rdy), .live_ctrl_rdy(live_ctrl_rdy),
        .live_ecc_rdy(live_ecc_rdy), .live_err_seen(live_err_seen),
        .live_corr_cnt(live_corr_cnt), .live_dec_fail(live_dec_fail),
        .live_stat(live_stat)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // monitor: compares every read against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && flag_rd_en) begin
            if (rd_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R4: actual=%0h expected=none", flag_rd_data);
            end else begin
                chk("R4 read value", 32'(flag_rd_data), 32'(rd_q.pop_front()));
            end
        end
    end

    task automatic pulse(input int k);
        evt_i[k] = 1'b1;
        tick();
        exp_flags[k] = 1'b1;
        evt_i[k] = 1'b0;
        tick();
    endtask

    task automatic do_read(input logic [N-1:0] coincide);
        rd_q.push_back(exp_flags);
        flag_rd_en = 1'b1;
        evt_i = evt_i | coincide;
        tick();
        flag_rd_en = 1'b0;
        exp_flags = coincide;
    endtask

    task automatic set_mask(input logic [N-1:0] m);
        mask_wr_en = 1'b1;
        mask_wr_data = m;
        tick();
        mask_wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1
        chk("R1 flags", 32'(flag_rd_data), 0);
        chk("R1 mask", 32'(mask_q), 0);
        chk("R1 irq", 32'(irq), 0);

        // R2: each source alone, flag lands at the expected position
        for (int k = 0; k < N; k++) begin
            pulse(k);
            chk("R2 single flag", 32'(flag_rd_data), 32'(exp_flags));
            do_read('0);
            #1 evt_i = '0;
            chk("R4 cleared", 32'(flag_rd_data), 0);
        end

        // R9: accumulation
        pulse(1); pulse(4); pulse(0);
        chk("R9 accumulate", 32'(flag_rd_data), 32'h13);
        chk("R6 masked off", 32'(irq), 0);

        // R3 / R6
        set_mask(6'b010000);
        chk("R3 mask", 32'(mask_q), 32'h10);
        chk("R6 irq on", 32'(irq), 1);
        set_mask(6'b100000);
        chk("R6 irq off by mask", 32'(irq), 0);
        set_mask(6'b000011);
        chk("R6 irq low bits", 32'(irq), 1);
        do_read('0);
        chk("R6 irq cleared", 32'(irq), 0);

        // R5: event at the clearing edge survives
        pulse(2);
        do_read(6'b001000);
        evt_i = '0;
        chk("R5 kept", 32'(flag_rd_data), 32'h08);
        do_read('0);
        chk("R5 then cleared", 32'(flag_rd_data), 0);

        // R2: held level does not re-set after clear
        evt_i[5] = 1'b1;
        tick();
        exp_flags[5] = 1'b1;
        tick();
        do_read('0);
        tick();
        chk("R2 held level", 32'(flag_rd_data), 0);
        evt_i[5] = 1'b0;
        tick();

        // R7 / R8: live word
        live_nand_rdy = 1; live_ecc_rdy = 1; live_dec_fail = 1;
        #1 chk("R7 live mirror", 32'(live_stat), 32'h45);
        live_nand_rdy = 0; live_ecc_rdy = 0; live_dec_fail = 0; live_ctrl_rdy = 1;
        #1 chk("R7 ctrl bit", 32'(live_stat), 32'h02);
        live_ctrl_rdy = 0;
        live_corr_cnt = 3'd3;
        #1 chk("R8 not seen", 32'(live_stat), 32'h00);
        live_err_seen = 1;
        #1 chk("R8 count 3", 32'(live_stat), 32'h28);
        live_corr_cnt = 3'd1;
        #1 chk("R8 count 1", 32'(live_stat), 32'h08);
        live_corr_cnt = 3'd4;
        #1 chk("R8 count 4", 32'(live_stat), 32'h38);
        live_corr_cnt = 3'd7;
        #1 chk("R8 saturate", 32'(live_stat), 32'h38);
        live_corr_cnt = 3'd0;
        #1 chk("R8 zero", 32'(live_stat), 32'h08);
        tick();

        chk("R4 queue drained", 32'(rd_q.size()), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule